// File: doc/BRIEF.md
# Cascadable Up/Down Presettable Counter

This block is a synchronous binary counter that counts either up or down and can be preset from a parallel word. It is built from identical 4-bit stages. Each stage produces an active-low carry that feeds the trickle enable of the next stage, so a chain of stages acts as one wider counter without extra gating. The parameter `NUM_STAGES` sets the chain length. The stages share the clock, the direction select, the parallel count enable and the load strobe.

Both count enables are active low, and the count advances only when both are low. The load strobe is also active low and synchronous. It takes priority over counting, and on the next rising edge the counter takes the parallel data word. The carry output goes low at the terminal count of the current direction, which is all ones when counting up and zero when counting down. Only the trickle enable gates the carry; the parallel enable does not. The carry is combinational, so it follows a change of direction at once. An active-low asynchronous reset clears the count.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0. The reset acts asynchronously, without waiting for a clock edge.
- R2: When `load_ni` is low at a rising edge, `count_o` becomes `data_i` after that edge. The enables and `up_i` have no effect on that edge.
- R3: When `load_ni` is high and both `cnt_en_ni` and `chain_en_ni` are low at a rising edge, `count_o` changes after that edge. It rises by 1 if `up_i` is 1 and falls by 1 if `up_i` is 0.
- R4: Counting wraps modulo 2^W, where W = 4*NUM_STAGES. All ones counting up goes to 0, and 0 counting down goes to all ones. The result is the same across stage boundaries as for a single W-bit counter.
- R5: `carry_no` is low exactly when `chain_en_ni` is low and `count_o` is at its terminal count. The terminal count is all ones when `up_i`=1 and 0 when `up_i`=0. The output is combinational and follows `up_i` and `chain_en_ni` without a clock edge.
- R6: `cnt_en_ni` has no effect on `carry_no`.
- R7: When `load_ni` is high and either `cnt_en_ni` or `chain_en_ni` is high at a rising edge, `count_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the count |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_en_ni | input | 1 | Parallel count enable, active low, shared by all stages |
| chain_en_ni | input | 1 | Trickle enable of the first stage, active low; also gates the carry |
| load_ni | input | 1 | Synchronous parallel load, active low |
| data_i | input | 4*NUM_STAGES | Preset value |
| count_o | output | 4*NUM_STAGES | Current count |
| carry_no | output | 1 | Ripple carry of the last stage, active low |

## Verification
The hardest case to reach from the ports is a carry crossing a stage boundary. Most count values never make the lower stage's carry enable the upper stage. The stimulus therefore loads every one of the 256 values of the two-stage configuration. From each value it takes one step up and one step down, so every borrow and carry crossing, including both full wraps, is exercised. At each loaded value the carry output is compared against all combinations of direction, trickle enable and parallel enable, with no clock edge between the changes. This shows that the carry follows direction at once and ignores the parallel enable.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int unsigned STAGE_W = 4;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } stage_mode_e;

  // load wins over counting; counting needs both enables low
  function automatic stage_mode_e decode_mode(input logic load_n,
                                              input logic cnt_en_n,
                                              input logic chain_en_n);
    if (!load_n)                     return MODE_LOAD;
    else if (!cnt_en_n && !chain_en_n) return MODE_COUNT;
    else                             return MODE_HOLD;
  endfunction

endpackage

// File: rtl/updn_tc_detect.sv
module updn_tc_detect #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic         up_i,
  input  logic         chain_en_ni,
  output logic         rco_no
);
  logic at_max, at_min, at_tc;

  assign at_max = &q_i;
  assign at_min = ~|q_i;
  assign at_tc  = up_i ? at_max : at_min;
  assign rco_no = ~(~chain_en_ni & at_tc);
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int unsigned W = STAGE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         cnt_en_ni,
  input  logic         chain_en_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o,
  output logic         rco_no
);
  logic [W-1:0] q_q, q_d, step;
  stage_mode_e  mode;

  assign mode = decode_mode(load_ni, cnt_en_ni, chain_en_ni);
  assign step = up_i ? W'(1) : {W{1'b1}};

  always_comb begin
    unique case (mode)
      MODE_LOAD:  q_d = data_i;
      MODE_COUNT: q_d = q_q + step;
      default:    q_d = q_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  updn_tc_detect #(.W(W)) u_tc (
    .q_i        (q_q),
    .up_i       (up_i),
    .chain_en_ni(chain_en_ni),
    .rco_no     (rco_no)
  );

  assign q_o = q_q;
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 2,
  localparam int unsigned W = STAGE_W * NUM_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         up_i,
  input  logic         cnt_en_ni,
  input  logic         chain_en_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         carry_no
);
  // chain_n[k] is the trickle enable of stage k; last entry is the chain carry
  logic [NUM_STAGES:0] chain_n;

  assign chain_n[0] = chain_en_ni;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    updn_stage #(.W(STAGE_W)) u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .up_i       (up_i),
      .cnt_en_ni  (cnt_en_ni),
      .chain_en_ni(chain_n[k]),
      .load_ni    (load_ni),
      .data_i     (data_i[k*STAGE_W +: STAGE_W]),
      .q_o        (count_o[k*STAGE_W +: STAGE_W]),
      .rco_no     (chain_n[k+1])
    );
  end

  assign carry_no = chain_n[NUM_STAGES];
endmodule

// File: rtl/updn_cascade_counter_chk.sv
module updn_cascade_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         up_i,
  input logic         cnt_en_ni,
  input logic         chain_en_ni,
  input logic         load_ni,
  input logic [W-1:0] data_i,
  input logic [W-1:0] count_o,
  input logic         carry_no
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);

  // R2
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  // R3 R4
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && !chain_en_ni && up_i) |=> count_o == W'($past(count_o) + 1'b1));

  // R3 R4
  count_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && !chain_en_ni && !up_i) |=> count_o == W'($past(count_o) - 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (cnt_en_ni || chain_en_ni)) |=> $stable(count_o));

  // R5 R6
  carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !carry_no == (!chain_en_ni && (up_i ? (&count_o) : (count_o == '0))));
endmodule

bind updn_cascade_counter updn_cascade_counter_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .up_i       (up_i),
  .cnt_en_ni  (cnt_en_ni),
  .chain_en_ni(chain_en_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .count_o    (count_o),
  .carry_no   (carry_no)
);

// File: tb/tb_updn_cascade_counter.sv
`timescale 1ns/1ps
module tb_updn_cascade_counter;
  localparam int unsigned NS = 2;
  localparam int unsigned W  = 4 * NS;
  localparam int unsigned MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_ni, up_i, cnt_en_ni, chain_en_ni, load_ni;
  logic [W-1:0] data_i, count_o;
  logic         carry_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  updn_cascade_counter #(.NUM_STAGES(NS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .up_i(up_i), .cnt_en_ni(cnt_en_ni),
    .chain_en_ni(chain_en_ni), .load_ni(load_ni), .data_i(data_i),
    .count_o(count_o), .carry_no(carry_no)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic exp_carry(input int v, input logic up, input logic chn);
    return !(!chn && (up ? (v == MAXV) : (v == 0)));
  endfunction

  task automatic edge_step(input logic ld, input logic ce, input logic ch, input logic up,
                           input int d);
    @(negedge clk);
    load_ni = ld; cnt_en_ni = ce; chain_en_ni = ch; up_i = up; data_i = W'(d);
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_ni = 1'b0; up_i = 1'b1; cnt_en_ni = 1'b1; chain_en_ni = 1'b1;
    load_ni = 1'b1; data_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset count", int'(count_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int v = 0; v <= int'(MAXV); v++) begin
      // R2: load with enables active and both directions; load must win
      edge_step(1'b0, 1'b0, 1'b0, v[0], v);
      chk("R2 load", int'(count_o), v);

      // R5 R6: combinational carry, no clock edge between changes
      @(negedge clk);
      load_ni = 1'b1;
      for (int c = 0; c < 8; c++) begin
        up_i = c[0]; chain_en_ni = c[1]; cnt_en_ni = c[2];
        #0.2;
        chk(c[2] ? "R6 carry vs cnt_en" : "R5 carry", int'(carry_no),
            int'(exp_carry(v, c[0], c[1])));
      end

      // R3 R4 up, then down back
      edge_step(1'b1, 1'b0, 1'b0, 1'b1, 0);
      chk("R3 R4 count up", int'(count_o), (v + 1) & int'(MAXV));
      edge_step(1'b1, 1'b0, 1'b0, 1'b0, 0);
      chk("R3 count down", int'(count_o), v);
      edge_step(1'b1, 1'b0, 1'b0, 1'b0, 0);
      chk("R3 R4 count down", int'(count_o), (v + int'(MAXV)) & int'(MAXV));

      // R7 holds
      edge_step(1'b1, 1'b1, 1'b0, 1'b1, 0);
      chk("R7 hold cnt_en high", int'(count_o), (v + int'(MAXV)) & int'(MAXV));
      edge_step(1'b1, 1'b0, 1'b1, 1'b1, 0);
      chk("R7 hold chain_en high", int'(count_o), (v + int'(MAXV)) & int'(MAXV));
    end

    // R1 asynchronous: reset mid-cycle clears without an edge
    edge_step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
    chk("R2 load A5", int'(count_o), 8'hA5);
    @(negedge clk);
    load_ni = 1'b1;
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async reset", int'(count_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule